// File: doc/BRIEF.md
# Trace Unit Programming-Mode Controller

This block is the register front end of a processor trace unit. It owns the gating that decides whether software can reach the trace registers at all. A lock stage starts set and is cleared by any write to its register. A power-up request bit must be set in the power control register. Together these two gate every trace register behind them. Inside the control register, a power-down bit further blocks writes to configuration registers.

The control register also carries a programming bit, which is set out of reset. Setting it halts tracing at once. A delayed copy of it appears in the status register, and software polls that copy for both the rising and the falling transition before touching configuration. Tracing runs only while the enable bit is set, the programming bit is clear, the unit is powered and unlocked.

Two read-only registers report the architecture version and the unit's resource counts. One configuration register, the synchronisation period, stands in for the configuration space that this gating protects. The block exports a write-permission flag so that the wider configuration space can use the same rule.

Top module: `trc_prog_ctrl`

## Requirements
- R1: After reset the unit is locked, the power-up request is 0, the control register reads 3 (power-down bit 0 = 1, programming bit 1 = 1, enable bit 2 = 0), status bit 0 reads 1, the sync period reads 1024, and trace_active and cfg_wr_ok are 0.
- R2: A write of any data to the lock register (word 3) clears the lock. Bit 0 of that register reads the lock state. The lock register and the power register (word 2) are reachable in any state.
- R3: The power register holds the power-up request at bit 3. The control (word 0), status (word 1), ID (word 4), capability (word 5) and sync (word 6) registers are accessible only while the unit is unlocked and the power-up request is 1. Otherwise their reads return 0 and writes to them are dropped.
- R4: cfg_wr_ok is 1 exactly when those registers are accessible, the power-down bit is 0 and the programming status is 1. A write to the sync register is applied only when cfg_wr_ok is 1 and is otherwise ignored.
- R5: Status bit 0 follows the control register's programming bit with a latency of 2 clock cycles.
- R6: trace_active is enable AND NOT programming AND power-up request AND NOT power-down AND NOT locked. A write that sets the programming bit drops trace_active in the cycle after the write.
- R7: The ID register reads the ARCH_VER parameter in bits 11:4 and 0 elsewhere.
- R8: The capability register reads address-comparator pairs in bits 3:0, counters in 15:13, external inputs in 19:17, external outputs in 22:20 and context-ID comparators in 25:24, all from parameters, with 0 elsewhere.
- R9: The sync register is SYNC_W (12) bits wide and resets to 1024. Write data above that width is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | AW | Word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, combinational, 0 when not reading |
| cfg_wr_ok | output | 1 | Configuration registers may be written |
| trace_active | output | 1 | Tracing is running |

## Verification
Most faults in the gating state show up at once as read data. A lock or power flag that is wrong turns a gated read to zero, or makes it non-zero, in the same cycle as the access. A wrong programming pipeline shows at the status bit exactly two edges after a control write, so the bench samples the status register on each of those cycles. A wrong trace_active term appears in the half cycle after the write that changes it, and the bench sweeps each gating input one at a time to expose it.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_PWR  = 2;
  localparam int unsigned OFS_LOCK = 3;
  localparam int unsigned OFS_ID   = 4;
  localparam int unsigned OFS_CAP  = 5;
  localparam int unsigned OFS_SYNC = 6;

  localparam int unsigned CTRL_W        = 3;
  localparam int unsigned PWR_UP_BIT    = 3;
  localparam int unsigned STAT_PROG_BIT = 0;
  localparam int unsigned LOCK_BIT      = 0;
  localparam int unsigned ID_ARCH_LO    = 4;
  localparam int unsigned CAP_ACMP_LO   = 0;
  localparam int unsigned CAP_CNT_LO    = 13;
  localparam int unsigned CAP_EIN_LO    = 17;
  localparam int unsigned CAP_EOUT_LO   = 20;
  localparam int unsigned CAP_CID_LO    = 24;

  typedef struct packed {
    logic en;
    logic prog;
    logic pwroff;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, prog: 1'b1, pwroff: 1'b1};
endpackage

// File: rtl/trc_gate.sv
module trc_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_lock,
  input  logic wr_pwr,
  input  logic pwr_up_wdata,
  output logic locked,
  output logic pwr_up
);
  logic locked_d, pwr_up_d;
  logic lock_en, pwr_en;

  always_comb begin
    lock_en  = wr_lock;
    locked_d = 1'b0;
    pwr_en   = wr_pwr;
    pwr_up_d = pwr_up_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      pwr_up <= 1'b0;
    end else begin
      if (lock_en) locked <= locked_d;
      if (pwr_en)  pwr_up <= pwr_up_d;
    end
  end
endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
  import trc_pkg::*;
#(
  parameter int unsigned PROG_LAT = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  ctrl_t ctrl_wdata,
  output ctrl_t ctrl_q,
  output logic  prog_stat
);
  ctrl_t ctrl_d;
  logic  ctrl_en;

  always_comb begin
    ctrl_en = wr_ctrl;
    ctrl_d  = ctrl_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  generate
    if (PROG_LAT == 0) begin : g_direct
      assign prog_stat = ctrl_q.prog;
    end else begin : g_pipe
      logic [PROG_LAT-1:0] pipe_q, pipe_d;
      always_comb begin
        pipe_d[0] = ctrl_q.prog;
        for (int i = 1; i < int'(PROG_LAT); i++) pipe_d[i] = pipe_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
      end
      assign prog_stat = pipe_q[PROG_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/trc_cfg_reg.sv
module trc_cfg_reg #(
  parameter int unsigned W   = 12,
  parameter logic [W-1:0] RST = W'(1024)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    en = wr;
    d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST;
    else if (en) q <= d;
  end
endmodule

// File: rtl/trc_rdmux.sv
module trc_rdmux
  import trc_pkg::*;
#(
  parameter int unsigned AW           = 3,
  parameter int unsigned DW           = 32,
  parameter int unsigned SYNC_W       = 12,
  parameter logic [7:0]  ARCH_VER     = 8'h21,
  parameter logic [3:0]  N_ACMP_PAIRS = 4'd4,
  parameter logic [2:0]  N_CNT        = 3'd2,
  parameter logic [2:0]  N_EXT_IN     = 3'd3,
  parameter logic [2:0]  N_EXT_OUT    = 3'd1,
  parameter logic [1:0]  N_CID        = 2'd1
) (
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic              regs_ok,
  input  logic              locked,
  input  logic              pwr_up,
  input  ctrl_t             ctrl_q,
  input  logic              prog_stat,
  input  logic [SYNC_W-1:0] sync_q,
  output logic [DW-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == AW'(OFS_LOCK)) begin
        rdata[LOCK_BIT] = locked;
      end else if (addr == AW'(OFS_PWR)) begin
        rdata[PWR_UP_BIT] = pwr_up;
      end else if (regs_ok) begin
        if (addr == AW'(OFS_CTRL)) begin
          rdata[CTRL_W-1:0] = ctrl_q;
        end else if (addr == AW'(OFS_STAT)) begin
          rdata[STAT_PROG_BIT] = prog_stat;
        end else if (addr == AW'(OFS_ID)) begin
          rdata[ID_ARCH_LO +: 8] = ARCH_VER;
        end else if (addr == AW'(OFS_CAP)) begin
          rdata[CAP_ACMP_LO +: 4] = N_ACMP_PAIRS;
          rdata[CAP_CNT_LO  +: 3] = N_CNT;
          rdata[CAP_EIN_LO  +: 3] = N_EXT_IN;
          rdata[CAP_EOUT_LO +: 3] = N_EXT_OUT;
          rdata[CAP_CID_LO  +: 2] = N_CID;
        end else if (addr == AW'(OFS_SYNC)) begin
          rdata[SYNC_W-1:0] = sync_q;
        end
      end
    end
  end
endmodule

// File: rtl/trc_prog_ctrl.sv
module trc_prog_ctrl
  import trc_pkg::*;
#(
  parameter int unsigned AW           = 3,
  parameter int unsigned DW           = 32,
  parameter int unsigned SYNC_W       = 12,
  parameter int unsigned SYNC_RST     = 1024,
  parameter int unsigned PROG_LAT     = 2,
  parameter logic [7:0]  ARCH_VER     = 8'h21,
  parameter logic [3:0]  N_ACMP_PAIRS = 4'd4,
  parameter logic [2:0]  N_CNT        = 3'd2,
  parameter logic [2:0]  N_EXT_IN     = 3'd3,
  parameter logic [2:0]  N_EXT_OUT    = 3'd1,
  parameter logic [1:0]  N_CID        = 2'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_en,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          cfg_wr_ok,
  output logic          trace_active
);
  localparam logic [SYNC_W-1:0] SYNC_RST_V = SYNC_W'(SYNC_RST);

  logic              locked, pwr_up, regs_ok, prog_stat;
  logic              wr_any, wr_lock, wr_pwr, wr_ctrl, wr_sync, rd_en;
  ctrl_t             ctrl_q;
  logic [SYNC_W-1:0] sync_q;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DW-1:SYNC_W];

  always_comb begin
    wr_any    = reg_en & reg_we;
    rd_en     = reg_en & ~reg_we;
    regs_ok   = ~locked & pwr_up;
    cfg_wr_ok = regs_ok & ~ctrl_q.pwroff & prog_stat;
    wr_lock   = wr_any & (reg_addr == AW'(OFS_LOCK));
    wr_pwr    = wr_any & (reg_addr == AW'(OFS_PWR));
    wr_ctrl   = wr_any & regs_ok & (reg_addr == AW'(OFS_CTRL));
    wr_sync   = wr_any & cfg_wr_ok & (reg_addr == AW'(OFS_SYNC));
    trace_active = ctrl_q.en & ~ctrl_q.prog & pwr_up & ~ctrl_q.pwroff & ~locked;
  end

  trc_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_lock      (wr_lock),
    .wr_pwr       (wr_pwr),
    .pwr_up_wdata (reg_wdata[PWR_UP_BIT]),
    .locked       (locked),
    .pwr_up       (pwr_up)
  );

  trc_ctrl #(.PROG_LAT(PROG_LAT)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .ctrl_wdata (ctrl_t'(reg_wdata[CTRL_W-1:0])),
    .ctrl_q     (ctrl_q),
    .prog_stat  (prog_stat)
  );

  trc_cfg_reg #(.W(SYNC_W), .RST(SYNC_RST_V)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr_sync),
    .wdata (reg_wdata[SYNC_W-1:0]),
    .q     (sync_q)
  );

  trc_rdmux #(
    .AW(AW), .DW(DW), .SYNC_W(SYNC_W), .ARCH_VER(ARCH_VER),
    .N_ACMP_PAIRS(N_ACMP_PAIRS), .N_CNT(N_CNT), .N_EXT_IN(N_EXT_IN),
    .N_EXT_OUT(N_EXT_OUT), .N_CID(N_CID)
  ) u_rd (
    .rd_en     (rd_en),
    .addr      (reg_addr),
    .regs_ok   (regs_ok),
    .locked    (locked),
    .pwr_up    (pwr_up),
    .ctrl_q    (ctrl_q),
    .prog_stat (prog_stat),
    .sync_q    (sync_q),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/trc_prog_ctrl_chk.sv
module trc_prog_ctrl_chk
  import trc_pkg::*;
#(
  parameter int unsigned AW     = 3,
  parameter int unsigned DW     = 32,
  parameter int unsigned SYNC_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_en,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic [DW-1:0]     reg_rdata,
  input logic              locked,
  input logic              pwr_up,
  input logic              prog_q,
  input logic              prog_stat,
  input logic [SYNC_W-1:0] sync_q,
  input logic              cfg_wr_ok,
  input logic              trace_active
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_lock_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && reg_we && reg_addr == AW'(OFS_LOCK)) |=> !locked);

  p_gated_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we && (locked || !pwr_up) &&
     reg_addr != AW'(OFS_LOCK) && reg_addr != AW'(OFS_PWR)) |-> (reg_rdata == '0));

  p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr_ok |=> $stable(sync_q));

  p_prog_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3) |-> (prog_stat == $past(prog_q, 2)));

  p_prog_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_q |-> !trace_active);

  p_gate_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked || !pwr_up) |-> (!trace_active && !cfg_wr_ok));
endmodule

bind trc_prog_ctrl trc_prog_ctrl_chk #(.AW(AW), .DW(DW), .SYNC_W(SYNC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_en       (reg_en),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata),
  .locked       (locked),
  .pwr_up       (pwr_up),
  .prog_q       (ctrl_q.prog),
  .prog_stat    (prog_stat),
  .sync_q       (sync_q),
  .cfg_wr_ok    (cfg_wr_ok),
  .trace_active (trace_active)
);

// File: tb/trc_prog_ctrl_bench.sv
`timescale 1ns/1ps
module trc_prog_ctrl_bench;
  localparam int AW = 3;
  localparam int DW = 32;
  localparam logic [7:0] ARCH = 8'h21;
  localparam int PAIRS = 4, CNT = 2, EIN = 3, EOUT = 1, CID = 1;
  localparam int A_CTRL = 0, A_STAT = 1, A_PWR = 2, A_LOCK = 3;
  localparam int A_ID = 4, A_CAP = 5, A_SYNC = 6;

  logic clk, rst_n, reg_en, reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic cfg_wr_ok, trace_active;
  int checks = 0, errors = 0;
  logic [31:0] d;

  trc_prog_ctrl #(
    .AW(AW), .DW(DW), .SYNC_W(12), .SYNC_RST(1024), .PROG_LAT(2),
    .ARCH_VER(ARCH), .N_ACMP_PAIRS(4'(PAIRS)), .N_CNT(3'(CNT)),
    .N_EXT_IN(3'(EIN)), .N_EXT_OUT(3'(EOUT)), .N_CID(2'(CID))
  ) u_trc_prog_ctrl (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = v;
    @(posedge clk); #1;
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = AW'(a);
    #1 v = reg_rdata;
    reg_en = 1'b0;
  endtask

  function automatic logic [31:0] cw(input bit pwroff, input bit prog, input bit en);
    return {29'd0, en, prog, pwroff};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reset_checks(input string tag);
    rd(A_LOCK, d);   check({tag, " lock set"}, d, 32'd1);
    check({tag, " trace_active"}, {31'd0, trace_active}, 32'd0);
    check({tag, " cfg_wr_ok"}, {31'd0, cfg_wr_ok}, 32'd0);
    rd(A_PWR, d);    check({tag, " pwr req"}, d, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    reset_checks("R1");
    rd(A_CTRL, d); check("R3 ctrl read while locked", d, 32'd0);
    wr(A_PWR, 32'h8);
    rd(A_PWR, d);  check("R3 pwr bit3", d, 32'h8);
    rd(A_SYNC, d); check("R3 sync read while locked", d, 32'd0);
    wr(A_CTRL, cw(0, 0, 1));
    wr(A_LOCK, 32'hDEAD_BEEF);
    rd(A_LOCK, d); check("R2 lock cleared", d, 32'd0);
    rd(A_CTRL, d); check("R1/R3 ctrl reset, locked write dropped", d, cw(1, 1, 0));
    rd(A_STAT, d); check("R1 status prog", d, 32'd1);
    rd(A_SYNC, d); check("R9 sync reset", d, 32'd1024);
    rd(A_ID, d);   check("R7 id", d, {20'd0, ARCH, 4'd0});
    rd(A_CAP, d);  check("R8 cap", d, PAIRS | (CNT << 13) | (EIN << 17) | (EOUT << 20) | (CID << 24));
    check("R4 cfg_wr_ok low while powered down", {31'd0, cfg_wr_ok}, 32'd0);
    wr(A_SYNC, 32'd77);
    rd(A_SYNC, d); check("R4 sync write dropped", d, 32'd1024);

    wr(A_CTRL, cw(0, 1, 0));
    rd(A_CTRL, d); check("R4 ctrl prog mode", d, cw(0, 1, 0));
    check("R4 cfg_wr_ok high", {31'd0, cfg_wr_ok}, 32'd1);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      v = 32'h0001_2345 * (i + 1) + 32'h1F0;
      wr(A_SYNC, v);
      rd(A_SYNC, d); check("R9 sync width sweep", d, v & 32'hFFF);
    end

    wr(A_CTRL, cw(0, 0, 1));
    rd(A_STAT, d); check("R5 status after 1 edge", d, 32'd1);
    check("R6 active once prog cleared", {31'd0, trace_active}, 32'd1);
    rd(A_STAT, d); check("R5 status after 2 edges", d, 32'd1);
    rd(A_STAT, d); check("R5 status after 3 edges", d, 32'd0);
    check("R4 cfg_wr_ok low when out of prog", {31'd0, cfg_wr_ok}, 32'd0);
    wr(A_SYNC, 32'd5);
    rd(A_SYNC, d); check("R4 sync ignored out of prog", d, 32'h1F0 + 32'h0001_2345 * 8 & 32'hFFF);

    wr(A_CTRL, cw(0, 1, 1));
    check("R6 prog halts trace", {31'd0, trace_active}, 32'd0);
    rd(A_STAT, d); check("R5 status rise 1", d, 32'd0);
    rd(A_STAT, d); check("R5 status rise 2", d, 32'd0);
    rd(A_STAT, d); check("R5 status rise 3", d, 32'd1);

    wr(A_CTRL, cw(0, 0, 1));
    check("R6 resume", {31'd0, trace_active}, 32'd1);
    wr(A_CTRL, cw(1, 0, 1));
    check("R6 pwroff halts", {31'd0, trace_active}, 32'd0);
    wr(A_CTRL, cw(0, 0, 0));
    check("R6 enable low halts", {31'd0, trace_active}, 32'd0);
    wr(A_CTRL, cw(0, 0, 1));
    wr(A_PWR, 32'h0);
    check("R6 power request low halts", {31'd0, trace_active}, 32'd0);
    rd(A_CTRL, d); check("R3 ctrl read unpowered", d, 32'd0);
    wr(A_CTRL, cw(0, 1, 0));
    wr(A_PWR, 32'hFFFF_FFF7);
    rd(A_PWR, d); check("R3 other pwr bits ignored", d, 32'd0);
    wr(A_PWR, 32'h8);
    rd(A_CTRL, d); check("R3 unpowered ctrl write dropped", d, cw(0, 0, 1));
    check("R6 active again", {31'd0, trace_active}, 32'd1);

    do_reset();
    reset_checks("R1 mid-run reset");
    wr(A_PWR, 32'h8);
    wr(A_LOCK, 32'h0);
    rd(A_SYNC, d); check("R1 sync after reset", d, 32'd1024);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule